// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. It takes the accumulator, a second operand, the incoming carry and a 3-bit opcode. It computes an 8-bit result and a write-enable that tells the register file whether to store that result back into the accumulator. It also computes a five-flag status byte in a fixed sparse layout, and that byte is held in a flag register.

The result and the write-enable are combinational, so they follow the inputs within the same cycle. The flag register loads the status byte of the current operation on every rising clock edge. Asynchronous reset clears the flag register. Instruction decode and the register file belong to the surrounding datapath.

Top module: `alu8_flags`

## Requirements
- R1: Opcode 0 gives acc + opnd and opcode 1 gives acc + opnd + cin, both truncated to 8 bits, with the write-enable at 1.
- R2: Opcode 2 gives acc - opnd and opcode 3 gives acc - opnd - cin, both modulo 256, with the write-enable at 1.
- R3: Opcode 4 gives acc AND opnd, opcode 5 gives acc XOR opnd and opcode 6 gives acc OR opnd, with the write-enable at 1.
- R4: Opcode 7 (compare) drives the difference acc - opnd on the result and holds the write-enable at 0, so the accumulator keeps its value. Its flags are those that opcode 2 would give.
- R5: The flag byte puts sign at bit 7, zero at bit 6, auxiliary carry at bit 4, parity at bit 2 and carry at bit 0. Bits 5, 3 and 1 are always 0.
- R6: The sign flag equals bit 7 of the 8-bit result.
- R7: The zero flag is 1 exactly when the 8-bit result is 00h.
- R8: The parity flag is 1 when the result holds an even number of 1 bits, and 0 otherwise.
- R9: For additions, carry is the carry out of bit 7. For subtract and compare, carry is 1 when the subtrahend, with any borrow-in added, exceeds the accumulator as unsigned values.
- R10: For additions, auxiliary carry is the carry out of bit 3. For subtract and compare, it is 1 when the low nibble of the subtrahend, with any borrow-in added, exceeds the low nibble of the accumulator.
- R11: Logical opcodes clear carry. AND sets auxiliary carry to 1, while XOR and OR clear it.
- R12: The flag register is cleared to 00h by reset. After that, it loads the status byte of the current inputs on each rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| cin_i | input | 1 | Incoming carry or borrow |
| op_i | input | 3 | Opcode |
| res_o | output | 8 | Combinational result |
| wr_en_o | output | 1 | Result write-enable, 0 for compare |
| flags_o | output | 8 | Registered flag byte |

## Verification
The assertions take the inputs to be stable across each clock edge. They compare the flag register with the result that was present one cycle earlier, which only works if the inputs behind that result do not move in the middle of a cycle. The bench changes the inputs only on the falling edge, so each vector is held for a full rising edge. The opcode is drawn over all eight codes, and the operands cover the full 8-bit range. Directed vectors add the carry, borrow, zero and nibble-boundary cases on top of the random ones.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  logic         cin_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] res_o,
  output logic         wr_en_o,
  output logic [7:0]   flags_o
);
  localparam int NW = W / 2;
  localparam logic [2:0] OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBB = 3'd3,
                         OP_AND = 3'd4, OP_XOR = 3'd5, OP_OR  = 3'd6, OP_CMP = 3'd7;

  logic          is_sub, is_logic, cuse;
  logic [W:0]    full;
  logic [NW:0]   lo;
  logic          cy, ac;
  logic [7:0]    flags_d;

  assign is_sub   = (op_i == OP_SUB) || (op_i == OP_SBB) || (op_i == OP_CMP);
  assign is_logic = (op_i == OP_AND) || (op_i == OP_XOR) || (op_i == OP_OR);
  assign cuse     = ((op_i == OP_ADC) || (op_i == OP_SBB)) ? cin_i : 1'b0;

  always_comb begin
    full = '0;
    lo   = '0;
    cy   = 1'b0;
    ac   = 1'b0;
    if (is_sub) begin
      full = {1'b0, acc_i} - {1'b0, opnd_i} - {{W{1'b0}}, cuse};
      lo   = {1'b0, acc_i[NW-1:0]} - {1'b0, opnd_i[NW-1:0]} - {{NW{1'b0}}, cuse};
      cy   = full[W];
      ac   = lo[NW];
    end else if (is_logic) begin
      case (op_i)
        OP_AND:  full = {1'b0, acc_i & opnd_i};
        OP_XOR:  full = {1'b0, acc_i ^ opnd_i};
        default: full = {1'b0, acc_i | opnd_i};
      endcase
      ac = (op_i == OP_AND);
    end else begin
      full = {1'b0, acc_i} + {1'b0, opnd_i} + {{W{1'b0}}, cuse};
      lo   = {1'b0, acc_i[NW-1:0]} + {1'b0, opnd_i[NW-1:0]} + {{NW{1'b0}}, cuse};
      cy   = full[W];
      ac   = lo[NW];
    end
  end

  assign res_o   = full[W-1:0];
  assign wr_en_o = (op_i != OP_CMP);
  assign flags_d = {res_o[W-1], (res_o == '0), 1'b0, ac, 1'b0, ~^res_o, 1'b0, cy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_o <= 8'h00;
    else        flags_o <= flags_d;
  end

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMP) |-> !wr_en_o); // R4
  AST_RSV_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_o & 8'h2A) == 8'h00)); // R5
  AST_SIGN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flags_o[7] == $past(res_o[W-1]))); // R6
  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flags_o[6] == ($past(res_o) == '0))); // R7
  AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flags_o[2] == ~^$past(res_o))); // R8
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    is_logic |=> !flags_o[0]); // R11
endmodule

// File: tb/tb_alu8_flags.sv
module tb_alu8_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] acc_i = '0, opnd_i = '0;
  logic cin_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [7:0] res_o, flags_o;
  logic wr_en_o;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu8_flags dut (.clk(clk), .rst_n(rst_n), .acc_i(acc_i), .opnd_i(opnd_i), .cin_i(cin_i),
                  .op_i(op_i), .res_o(res_o), .wr_en_o(wr_en_o), .flags_o(flags_o));

  function automatic logic [16:0] model(input logic [7:0] a, input logic [7:0] b,
                                        input logic c, input logic [2:0] op);
    int r, lo, cc, ones;
    logic cy, ac, w;
    logic [7:0] rv;
    w = (op != 3'd7);
    cc = (op == 3'd1 || op == 3'd3) ? int'(c) : 0;
    cy = 0; ac = 0; r = 0;
    case (op)
      3'd0, 3'd1: begin
        r = int'(a) + int'(b) + cc; lo = int'(a % 16) + int'(b % 16) + cc;
        cy = (r > 255); ac = (lo > 15);
      end
      3'd2, 3'd3, 3'd7: begin
        r = int'(a) - int'(b) - cc; lo = int'(a % 16) - int'(b % 16) - cc;
        cy = (r < 0); ac = (lo < 0);
      end
      3'd4: begin r = int'(a & b); ac = 1; end
      3'd5: r = int'(a ^ b);
      default: r = int'(a | b);
    endcase
    rv = r[7:0];
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(rv[i]);
    return {w, rv, rv[7], (rv == 8'h00), 1'b0, ac, 1'b0, (ones % 2 == 0), 1'b0, cy};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (op=%0d a=%0h b=%0h c=%0b)",
               tag, act, exp, op_i, acc_i, opnd_i, cin_i);
    end
  endtask

  task automatic run(input logic [7:0] a, input logic [7:0] b, input logic c, input logic [2:0] op);
    logic [16:0] e;
    @(negedge clk);
    acc_i = a; opnd_i = b; cin_i = c; op_i = op;
    e = model(a, b, c, op);
    #1;
    if (op <= 3'd1)      chk("R1 result", res_o, e[15:8]);
    else if (op <= 3'd3) chk("R2 result", res_o, e[15:8]);
    else if (op <= 3'd6) chk("R3 result", res_o, e[15:8]);
    else                 chk("R4 result", res_o, e[15:8]);
    chk("R4 write-enable", wr_en_o, e[16]);
    @(posedge clk); #1;
    chk("R12 flag load", flags_o, e[7:0]);
    chk("R5 reserved bits", flags_o & 8'h2A, 0);
    chk("R6 sign", flags_o[7], e[7]);
    chk("R7 zero", flags_o[6], e[6]);
    chk("R8 parity", flags_o[2], e[2]);
    if (op >= 3'd4 && op <= 3'd6) begin
      chk("R11 logic carry", flags_o[0], 0);
      chk("R11 logic aux", flags_o[4], op == 3'd4);
    end else begin
      chk("R9 carry", flags_o[0], e[0]);
      chk("R10 aux carry", flags_o[4], e[4]);
    end
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd4211);
    #1;
    chk("R12 reset flags", flags_o, 8'h00);
    repeat (2) @(posedge clk);
    #1;
    chk("R12 reset held", flags_o, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    run(8'h88, 8'h99, 1'b0, 3'd0);
    chk("R1 88+99 flags", flags_o, 8'h15);
    run(8'h13, 8'h24, 1'b0, 3'd2);
    chk("R2 13-24 result", res_o, 8'hEF);
    chk("R9 13-24 borrow", flags_o[0], 1);
    run(8'hFF, 8'h00, 1'b1, 3'd1);
    chk("R7 FF+0+1 zero", flags_o, 8'h55);
    run(8'h00, 8'h00, 1'b1, 3'd3);
    run(8'h10, 8'h01, 1'b0, 3'd2);
    run(8'h0F, 8'h01, 1'b0, 3'd0);
    run(8'h42, 8'h42, 1'b1, 3'd7);
    chk("R4 equal compare zero", flags_o[6], 1);
    run(8'h01, 8'h02, 1'b0, 3'd7);
    run(8'hF0, 8'h0F, 1'b0, 3'd4);
    run(8'hAA, 8'hAA, 1'b0, 3'd5);
    run(8'h80, 8'h01, 1'b1, 3'd6);
    for (int k = 0; k < 3000; k++)
      run(8'($urandom), 8'($urandom), 1'($urandom), 3'($urandom));
    done = 1;
  end

  initial begin
    for (int t = 0; t < 150000 && !done; t++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule